// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block produces the SCL timing for an I2C master. It counts peripheral clock cycles to form a low phase and a high phase. It also marks the point after SCL falls at which SDA may change. A downstream bit engine consumes three single-cycle strobes: end of low phase, end of high phase, and SDA hold done. The bit engine also takes the SCL level.

A 32-bit waveform word sets the timing. It has two 8-bit dividers, one for each phase, so the duty cycle need not be symmetric. It also has an exponent that scales both dividers by a power of two, and a hold count. Each phase lasts `div * 2^exp + OFFSET` cycles. The hold strobe fires `hold + 3` cycles after the fall, but never later than two cycles before the low phase ends. The word is sampled only when a phase begins, so software may rewrite it while the clock runs.

While `en_i` is high the generator runs low and high phases alternately. When `en_i` drops, it finishes the current low phase (if any) and the high phase, then parks with SCL high.

Top module: `i2c_scl_wavegen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_o` is 1 and all three strobes are 0.
- R2: A low phase holds `scl_o` at 0 for exactly `lo * 2^e + OFFSET` cycles, where `e` is the effective exponent. `low_end_o` pulses on the last of those cycles.
- R3: A high phase holds `scl_o` at 1 for exactly `hi * 2^e + OFFSET` cycles. `high_end_o` pulses on the last of those cycles.
- R4: The waveform word places the low divider in bits 7:0, the high divider in bits 15:8, the exponent in bits 19:16 and the hold count in bits 29:24. The two dividers act independently.
- R5: An exponent above `CKDIV_MAX` (default 7) is treated as `CKDIV_MAX`.
- R6: `hold_stb_o` pulses for one cycle, `hold + 3` cycles after the first low cycle. That is, it pulses on low-phase cycle index `hold + 3`, counting from 0.
- R7: If `hold + 3` exceeds `low_length - 2`, the hold strobe moves to index `low_length - 2`, so it always comes before `low_end_o`.
- R8: The waveform word is captured only when a phase starts. A change made during a phase has no effect on that phase and applies from the next one.
- R9: With the generator idle, raising `en_i` starts a low phase. `scl_o` reads 0 one clock edge later. After a high phase ends with `en_i` high, the next low phase starts immediately.
- R10: When `en_i` is low at the end of a high phase, the generator goes idle. A low phase in progress still completes, followed by a full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request |
| cfg_i | input | 32 | Waveform word: dividers, exponent, hold count |
| scl_o | output | 1 | Generated SCL level |
| low_end_o | output | 1 | Last cycle of the low phase |
| high_end_o | output | 1 | Last cycle of the high phase |
| hold_stb_o | output | 1 | SDA may change (hold delay elapsed) |

## Verification
All four outputs are registered-state decodes, so every result is due one clock edge after the stimulus that causes it. A start request shows as SCL low at the next edge. A phase boundary latches the new word on the same edge that flips SCL. The bench drives inputs on the falling clock edge and updates its behavioural model on the rising edge. It compares all outputs on the next falling edge, which is exactly when those results become due. Phase lengths and hold positions are also measured by counting sampled cycles from the observed SCL fall. These counts are compared with the formula, including the clamped exponent, the clamped hold, a word rewritten mid-phase and a stop request.

// File: rtl/i2c_wg_pkg.sv
package i2c_wg_pkg;
   localparam int CFG_W    = 32;
   localparam int LO_LSB   = 0;
   localparam int HI_LSB   = 8;
   localparam int EXP_LSB  = 16;
   localparam int HOLD_LSB = 24;
   localparam int HOLD_ADD = 3;

   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/i2c_wg_phase_len.sv
module i2c_wg_phase_len #(
   parameter int DIVW      = 8,
   parameter int EXPW      = 4,
   parameter int CKDIV_MAX = 7,
   parameter int OFFSET    = 4,
   parameter int CW        = 15
) (
   input  logic [DIVW-1:0] div_i,
   input  logic [EXPW-1:0] exp_i,
   output logic [CW-1:0]   len_o
);
   logic [EXPW-1:0] exp_eff;

   generate
      if ((2**EXPW) - 1 > CKDIV_MAX) begin : g_clamp
         assign exp_eff = (exp_i > EXPW'(CKDIV_MAX)) ? EXPW'(CKDIV_MAX) : exp_i;
      end else begin : g_pass
         assign exp_eff = exp_i;
      end
   endgenerate

   assign len_o = (CW'(div_i) << exp_eff) + CW'(OFFSET);
endmodule

// File: rtl/i2c_wg_hold.sv
module i2c_wg_hold #(
   parameter int HOLDW = 6,
   parameter int CW    = 15
) (
   input  logic [HOLDW-1:0] hold_i,
   input  logic [CW-1:0]    lo_len_i,
   output logic [CW-1:0]    idx_o
);
   import i2c_wg_pkg::*;
   logic [CW-1:0] raw;
   logic [CW-1:0] lim;

   assign raw   = CW'(hold_i) + CW'(HOLD_ADD);
   assign lim   = lo_len_i - CW'(2);
   assign idx_o = (raw < lim) ? raw : lim;
endmodule

// File: rtl/i2c_scl_wavegen.sv
module i2c_scl_wavegen #(
   parameter int DIVW      = 8,
   parameter int EXPW      = 4,
   parameter int HOLDW     = 6,
   parameter int OFFSET    = 4,
   parameter int CKDIV_MAX = 7
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        en_i,
   input  logic [31:0] cfg_i,
   output logic        scl_o,
   output logic        low_end_o,
   output logic        high_end_o,
   output logic        hold_stb_o
);
   import i2c_wg_pkg::*;

   localparam int MAXLEN = ((2**DIVW) - 1) * (2**CKDIV_MAX) + OFFSET;
   localparam int CW     = $clog2(MAXLEN + 1);

   generate
      if (DIVW > 8)                        begin : g_bad_divw  $error("DIVW wider than field"); end
      if (EXP_LSB + EXPW > HOLD_LSB)       begin : g_bad_expw  $error("EXPW overlaps hold");    end
      if (HOLD_LSB + HOLDW > CFG_W)        begin : g_bad_holdw $error("HOLDW exceeds word");     end
      if (OFFSET < 2)                      begin : g_bad_off   $error("OFFSET below 2");         end
      if (CKDIV_MAX > (2**EXPW) - 1)       begin : g_bad_ckmax $error("CKDIV_MAX unreachable");  end
   endgenerate

   logic          run_q;
   phase_e        ph_q;
   logic [CW-1:0] cnt_q;
   logic [31:0]   cfg_q;

   logic [CW-1:0] lo_len, hi_len, hold_idx;
   logic          last_lo, last_hi;

   i2c_wg_phase_len #(.DIVW(DIVW), .EXPW(EXPW), .CKDIV_MAX(CKDIV_MAX),
                      .OFFSET(OFFSET), .CW(CW)) i_lo_len (
      .div_i (cfg_q[LO_LSB +: DIVW]),
      .exp_i (cfg_q[EXP_LSB +: EXPW]),
      .len_o (lo_len)
   );

   i2c_wg_phase_len #(.DIVW(DIVW), .EXPW(EXPW), .CKDIV_MAX(CKDIV_MAX),
                      .OFFSET(OFFSET), .CW(CW)) i_hi_len (
      .div_i (cfg_q[HI_LSB +: DIVW]),
      .exp_i (cfg_q[EXP_LSB +: EXPW]),
      .len_o (hi_len)
   );

   i2c_wg_hold #(.HOLDW(HOLDW), .CW(CW)) i_hold (
      .hold_i   (cfg_q[HOLD_LSB +: HOLDW]),
      .lo_len_i (lo_len),
      .idx_o    (hold_idx)
   );

   assign last_lo = run_q && (ph_q == PH_LOW)  && (cnt_q == lo_len - CW'(1));
   assign last_hi = run_q && (ph_q == PH_HIGH) && (cnt_q == hi_len - CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         ph_q  <= PH_LOW;
         cnt_q <= '0;
         cfg_q <= '0;
      end else if (!run_q) begin
         if (en_i) begin
            run_q <= 1'b1;
            ph_q  <= PH_LOW;
            cnt_q <= '0;
            cfg_q <= cfg_i;
         end
      end else if (last_lo) begin
         ph_q  <= PH_HIGH;
         cnt_q <= '0;
         cfg_q <= cfg_i;
      end else if (last_hi) begin
         if (en_i) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
            cfg_q <= cfg_i;
         end else begin
            run_q <= 1'b0;
         end
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign scl_o      = !run_q || (ph_q == PH_HIGH);
   assign low_end_o  = last_lo;
   assign high_end_o = last_hi;
   assign hold_stb_o = run_q && (ph_q == PH_LOW) && (cnt_q == hold_idx);

   AST_CNT_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && ph_q == PH_LOW) |-> (cnt_q < lo_len)) else $error("low count overrun");   // R2
   AST_CNT_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && ph_q == PH_HIGH) |-> (cnt_q < hi_len)) else $error("high count overrun"); // R3
   AST_LOW_THEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_end_o |=> (scl_o && !low_end_o)) else $error("no high after low");             // R3
   AST_HOLD_BEFORE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_stb_o |-> (!scl_o && !low_end_o)) else $error("hold strobe misplaced");        // R7
   AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !low_end_o && !high_end_o) |=> $stable(cfg_q)) else $error("word moved"); // R8
   AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (high_end_o && en_i) |=> !scl_o) else $error("no restart");                         // R9
   AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (high_end_o && !en_i) |=> (scl_o && !hold_stb_o && !high_end_o)) else $error("no stop"); // R10
endmodule

// File: tb/test_i2c_scl_wavegen.sv
module test_i2c_scl_wavegen;
   localparam int OFFSET = 4;
   localparam int CKMAX  = 7;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        en_i;
   logic [31:0] cfg_i;
   logic        scl_o, low_end_o, high_end_o, hold_stb_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk_i = ~clk_i;

   i2c_scl_wavegen i_i2c_scl_wavegen (
      .clk_i, .rst_ni, .en_i, .cfg_i,
      .scl_o, .low_end_o, .high_end_o, .hold_stb_o
   );

   // word: lo[7:0] hi[15:8] exp[19:16] hold[29:24]
   function automatic logic [31:0] mk(int lo, int hi, int e, int hold);
      return {2'b00, 6'(hold), 4'b0000, 4'(e), 8'(hi), 8'(lo)};
   endfunction

   function automatic int plen(int dv, int e);
      int ee = (e > CKMAX) ? CKMAX : e;
      return dv * (1 << ee) + OFFSET;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model, stepped on each rising edge
   int          m_run = 0, m_ph = 0, m_cnt = 0;
   logic [31:0] m_cfg = '0;

   always @(posedge clk_i) begin
      int lo_l, hi_l;
      lo_l = plen(int'(m_cfg[7:0]),  int'(m_cfg[19:16]));
      hi_l = plen(int'(m_cfg[15:8]), int'(m_cfg[19:16]));
      if (!rst_ni) begin
         m_run = 0; m_ph = 0; m_cnt = 0; m_cfg = '0;
      end else if (m_run == 0) begin
         if (en_i) begin m_run = 1; m_ph = 0; m_cnt = 0; m_cfg = cfg_i; end
      end else if (m_ph == 0 && m_cnt == lo_l - 1) begin
         m_ph = 1; m_cnt = 0; m_cfg = cfg_i;
      end else if (m_ph == 1 && m_cnt == hi_l - 1) begin
         if (en_i) begin m_ph = 0; m_cnt = 0; m_cfg = cfg_i; end
         else m_run = 0;
      end else begin
         m_cnt++;
      end
   end

   always @(negedge clk_i) begin
      int lo_l, hi_l, hidx;
      lo_l = plen(int'(m_cfg[7:0]),  int'(m_cfg[19:16]));
      hi_l = plen(int'(m_cfg[15:8]), int'(m_cfg[19:16]));
      hidx = int'(m_cfg[29:24]) + 3;
      if (hidx > lo_l - 2) hidx = lo_l - 2;
      if (!done) begin
         chk(scl_o == (m_run == 0 || m_ph == 1), "R2 scl level", int'(scl_o), int'(m_run == 0 || m_ph == 1));
         chk(low_end_o == (m_run == 1 && m_ph == 0 && m_cnt == lo_l - 1), "R2 low_end",
             int'(low_end_o), int'(m_run == 1 && m_ph == 0 && m_cnt == lo_l - 1));
         chk(high_end_o == (m_run == 1 && m_ph == 1 && m_cnt == hi_l - 1), "R3 high_end",
             int'(high_end_o), int'(m_run == 1 && m_ph == 1 && m_cnt == hi_l - 1));
         chk(hold_stb_o == (m_run == 1 && m_ph == 0 && m_cnt == hidx), "R6 hold_stb",
             int'(hold_stb_o), int'(m_run == 1 && m_ph == 0 && m_cnt == hidx));
      end
   end

   task automatic wait_fall();
      bit seen_hi = 1'b0;
      for (int i = 0; i < 100000; i++) begin
         @(negedge clk_i);
         if (scl_o) seen_hi = 1'b1;
         else if (seen_hi) break;
      end
   endtask

   // called on the first sampled low cycle; returns low count, hold index, high count
   task automatic count_phases(output int n, output int hidx, output int h);
      n = 0; hidx = -1; h = 0;
      while (!scl_o && n < 100000) begin
         if (hold_stb_o) hidx = n;
         n++;
         @(negedge clk_i);
      end
      while (h < 100000) begin
         h++;
         if (high_end_o) break;
         @(negedge clk_i);
      end
   endtask

   task automatic measure(int elo, int ehi, int ehold, string tag);
      int n, hidx, h;
      wait_fall();
      count_phases(n, hidx, h);
      chk(n == elo,      {tag, " low length"},  n,    elo);
      chk(h == ehi,      {tag, " high length"}, h,    ehi);
      chk(hidx == ehold, {tag, " hold index"},  hidx, ehold);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n, hidx, h;
      rst_ni = 1'b0; en_i = 1'b0; cfg_i = mk(2, 2, 0, 0);
      repeat (3) @(negedge clk_i);
      chk(scl_o && !low_end_o && !high_end_o && !hold_stb_o, "R1 reset idle", int'(scl_o), 1);
      rst_ni = 1'b1;
      repeat (3) @(negedge clk_i);
      chk(scl_o && !hold_stb_o, "R1 idle without en", int'(scl_o), 1);

      en_i = 1'b1;
      @(negedge clk_i);
      chk(!scl_o, "R9 start one edge after en", int'(scl_o), 0);
      measure(6, 6, 3, "R2 symmetric");

      cfg_i = mk(5, 1, 1, 2);
      measure(14, 6, 5, "R4 asymmetric exp1");
      cfg_i = mk(7, 0, 0, 1);
      measure(11, 4, 4, "R4 fields");
      cfg_i = mk(0, 3, 0, 20);
      measure(4, 7, 2, "R7 hold clamp");
      cfg_i = mk(1, 0, 12, 0);
      measure(132, 4, 3, "R5 exponent clamp");
      cfg_i = mk(255, 2, 0, 0);
      measure(259, 6, 3, "R3 max divider");

      cfg_i = mk(3, 3, 0, 0);
      measure(7, 7, 3, "R6 hold base");
      wait_fall();
      cfg_i = mk(9, 1, 0, 0);
      count_phases(n, hidx, h);
      chk(n == 7,    "R8 low keeps old word",  n,    7);
      chk(hidx == 3, "R8 hold keeps old word", hidx, 3);
      chk(h == 5,    "R8 high takes new word", h,    5);

      wait_fall();
      en_i = 1'b0;
      count_phases(n, hidx, h);
      chk(n == 13, "R10 low completes",  n, 13);
      chk(h == 5,  "R10 high completes", h, 5);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk_i);
         chk(scl_o && !low_end_o && !high_end_o && !hold_stb_o, "R10 parked idle", int'(scl_o), 1);
      end
      en_i = 1'b1;
      @(negedge clk_i);
      chk(!scl_o, "R9 restart from idle", int'(scl_o), 0);
      repeat (5) @(negedge clk_i);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule